// File: doc/BRIEF.md
# DRAM Retention Test Sequencer

This block runs a complete retention characterization of one DRAM bank over a plain command interface. In each pass it writes a pattern word to every (row, column) location, then drops its refresh-enable output and lets the bank sit idle for a hold interval. After that it reads every location back and XORs each returned word with the value it wrote. Any set bit in that XOR marks a cell that could not hold its charge for the hold interval. The sequencer emits one failure record per mismatching word over a valid/ready channel.

The pattern value comes from an external generator. The block drives the generator with the current row, column and round, and takes the data word back in the same cycle. Each hold step runs the pattern and then its bitwise complement. The hold interval grows by a fixed amount from one step to the next: a base count plus step index times a step count, both counted in clock cycles. With base and step chosen to match 1.5 s and 128 ms at the real clock, this sweeps 1.5 s to 6.1 s. The whole sweep repeats for a programmable number of rounds. A running counter totals the mismatched bits, and a single-cycle done pulse closes the run.

Top module: `retention_sequencer`

## Requirements
- R1: While reset is asserted and directly after it, refresh_en is 1, cmd_valid, fail_valid and done are 0, and err_bits is 0.
- R2: In a write phase, every location is written once, in this order: column index innermost, then row ascending, starting at (0,0). cmd_write is 1, cmd_wdata equals pat_data XORed with all-ones when the pass is a complement pass, and refresh_en is 1.
- R3: The first read command of a pass is raised exactly N+2 cycles after the cycle in which the last write of that pass was accepted, where N = base_wait + step index × step_wait.
- R4: refresh_en is 0 from the cycle after the last write of a pass is accepted until that pass's last compare (and any failure report for it) completes. It is therefore 0 for every read command and every failure report.
- R5: Passes run in this order: for each round, for each step index from 0 up to STEPS-1, first the true pattern (fail_inv=0) and then the complement (fail_inv=1). A run issues ROUNDS×STEPS×2×ROWS×COLS writes and the same number of reads, with read addresses in the write order.
- R6: Each returned word is compared with the word written to that location. A nonzero XOR raises fail_valid with fail_row/fail_col set to the location, fail_mask set to the XOR, fail_step set to the step index and fail_inv set to 1 for a complement pass. A zero XOR produces no record.
- R7: While fail_valid is 1 and fail_ready is 0, the record stays unchanged and no memory command is issued.
- R8: err_bits is cleared when a run starts and then grows by the popcount of each nonzero mismatch mask. It never decreases during a run.
- R9: After the last pass, done is 1 for exactly one cycle. The block then returns to idle with refresh_en at 1 and issues no commands until the next start.
- R10: While cmd_valid is 1 and cmd_ready is 0, cmd_valid, cmd_write, cmd_row, cmd_col and cmd_wdata keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| base_wait | input | WAIT_W | Hold cycles at step index 0 |
| step_wait | input | WAIT_W | Extra hold cycles per step index |
| refresh_en | output | 1 | High allows the controller to refresh the bank |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command accepted |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_row | output | ROW_W | Row address |
| cmd_col | output | COL_W | Column word address |
| cmd_wdata | output | DATA_W | Write data |
| rd_valid | input | 1 | Read data return strobe |
| rd_data | input | DATA_W | Read data |
| pat_row | output | ROW_W | Row for the pattern generator |
| pat_col | output | COL_W | Column for the pattern generator |
| pat_round | output | RND_W | Round index for the pattern generator |
| pat_data | input | DATA_W | Pattern word for the addressed location, same cycle |
| fail_valid | output | 1 | Failure record valid |
| fail_ready | input | 1 | Failure record taken |
| fail_row | output | ROW_W | Failing row |
| fail_col | output | COL_W | Failing column word |
| fail_mask | output | DATA_W | XOR of read and expected data |
| fail_step | output | STEP_W | Hold step index |
| fail_inv | output | 1 | 1 when the complemented pattern was used |
| done | output | 1 | One-cycle end-of-run pulse |
| err_bits | output | ERR_W | Total mismatched bits in this run |

## Verification
Write commands and their data are due in the same cycle the bench sees them, because they come straight from the walker and the generator. The bench therefore checks them at each accepted handshake. The first read of a pass is due N+2 cycles after the last accepted write: one cycle to enter the hold state, N+1 cycles in it, then the read state. The bench timestamps both events on a free-running cycle count and compares the difference exactly. A failure record appears in the cycle after the clock edge that captured the read data, and err_bits updates on that same edge. The bench matches each record at its handshake against a list built in advance from the leak table, and checks err_bits only after done.

// File: rtl/rts_pkg.sv
package rts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WAIT,
    ST_RD_REQ,
    ST_RD_CMP,
    ST_REPORT,
    ST_NEXT
  } seq_state_e;
endpackage

// File: rtl/rts_addr_walk.sv
module rts_addr_walk #(
  parameter int ROWS = 1024,
  parameter int COLS = 128,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             last
);
  localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);

  assign last = (row == ROW_MAX) && (col == COL_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (clr) begin
      row <= '0;
      col <= '0;
    end else if (adv) begin
      if (col == COL_MAX) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rts_wait_timer.sv
module rts_wait_timer #(
  parameter int WAIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] load_val,
  output logic              expired
);
  logic [WAIT_W-1:0] remain;

  assign expired = (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remain <= '0;
    else if (load)       remain <= load_val;
    else if (!expired)   remain <= remain - 1'b1;
  end
endmodule

// File: rtl/rts_pass_ctr.sv
module rts_pass_ctr #(
  parameter int STEPS  = 37,
  parameter int ROUNDS = 16,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic              inv,
  output logic [STEP_W-1:0] step,
  output logic [RND_W-1:0]  rnd,
  output logic              last
);
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(STEPS - 1);
  localparam logic [RND_W-1:0]  RND_MAX  = RND_W'(ROUNDS - 1);

  assign last = inv && (step == STEP_MAX) && (rnd == RND_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv  <= 1'b0;
      step <= '0;
      rnd  <= '0;
    end else if (clr) begin
      inv  <= 1'b0;
      step <= '0;
      rnd  <= '0;
    end else if (adv) begin
      inv <= ~inv;
      if (inv) begin
        if (step == STEP_MAX) begin
          step <= '0;
          rnd  <= rnd + 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/retention_sequencer.sv
module retention_sequencer
  import rts_pkg::*;
#(
  parameter int ROWS   = 1024,
  parameter int COLS   = 128,
  parameter int DATA_W = 64,
  parameter int STEPS  = 37,
  parameter int ROUNDS = 16,
  parameter int WAIT_W = 32,
  parameter int ERR_W  = 32,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int RND_W  = (ROUNDS > 1) ? $clog2(ROUNDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] base_wait,
  input  logic [WAIT_W-1:0] step_wait,
  output logic              refresh_en,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_write,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic [DATA_W-1:0] cmd_wdata,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ROW_W-1:0]  pat_row,
  output logic [COL_W-1:0]  pat_col,
  output logic [RND_W-1:0]  pat_round,
  input  logic [DATA_W-1:0] pat_data,
  output logic              fail_valid,
  input  logic              fail_ready,
  output logic [ROW_W-1:0]  fail_row,
  output logic [COL_W-1:0]  fail_col,
  output logic [DATA_W-1:0] fail_mask,
  output logic [STEP_W-1:0] fail_step,
  output logic              fail_inv,
  output logic              done,
  output logic [ERR_W-1:0]  err_bits
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  // Hold length in cycles for a given step index.
  function automatic logic [WAIT_W-1:0] hold_cycles(
    input logic [WAIT_W-1:0] base, input logic [WAIT_W-1:0] incr,
    input logic [STEP_W-1:0] idx);
    return base + incr * WAIT_W'(idx);
  endfunction

  // Number of set bits in a mismatch mask.
  function automatic logic [CNT_W-1:0] ones(input logic [DATA_W-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < DATA_W; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  seq_state_e st, st_nx;

  logic [ROW_W-1:0]  row;
  logic [COL_W-1:0]  col;
  logic              cell_last, walk_clr, walk_adv;
  logic              inv, pass_last, pass_clr, pass_adv;
  logic [STEP_W-1:0] step;
  logic [RND_W-1:0]  rnd;
  logic              timer_load, timer_exp;
  logic [DATA_W-1:0] expect_w, mism, mask_q;

  // Named internal events, observed by the bound checker.
  logic evt_last_write, evt_wait_expired, evt_cmp, evt_cell_done;

  rts_addr_walk #(.ROWS(ROWS), .COLS(COLS)) u_walk (
    .clk(clk), .rst_n(rst_n), .clr(walk_clr), .adv(walk_adv),
    .row(row), .col(col), .last(cell_last));

  rts_pass_ctr #(.STEPS(STEPS), .ROUNDS(ROUNDS)) u_pass (
    .clk(clk), .rst_n(rst_n), .clr(pass_clr), .adv(pass_adv),
    .inv(inv), .step(step), .rnd(rnd), .last(pass_last));

  rts_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load),
    .load_val(hold_cycles(base_wait, step_wait, step)), .expired(timer_exp));

  assign expect_w = pat_data ^ {DATA_W{inv}};
  assign mism     = rd_data ^ expect_w;

  assign evt_last_write   = (st == ST_WRITE) && cmd_ready && cell_last;
  assign evt_wait_expired = (st == ST_WAIT) && timer_exp;
  assign evt_cmp          = (st == ST_RD_CMP) && rd_valid;
  assign evt_cell_done    = (evt_cmp && (mism == '0)) ||
                            ((st == ST_REPORT) && fail_ready);

  always_comb begin
    st_nx      = st;
    walk_clr   = 1'b0;
    walk_adv   = 1'b0;
    pass_clr   = 1'b0;
    pass_adv   = 1'b0;
    timer_load = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        st_nx    = ST_WRITE;
        walk_clr = 1'b1;
        pass_clr = 1'b1;
      end
      ST_WRITE: if (cmd_ready) begin
        if (cell_last) begin
          st_nx      = ST_WAIT;
          walk_clr   = 1'b1;
          timer_load = 1'b1;
        end else begin
          walk_adv = 1'b1;
        end
      end
      ST_WAIT:   if (timer_exp) st_nx = ST_RD_REQ;
      ST_RD_REQ: if (cmd_ready) st_nx = ST_RD_CMP;
      ST_RD_CMP, ST_REPORT: begin
        if (evt_cmp && (mism != '0)) begin
          st_nx = ST_REPORT;
        end else if (evt_cell_done) begin
          if (cell_last) begin
            st_nx = ST_NEXT;
          end else begin
            st_nx    = ST_RD_REQ;
            walk_adv = 1'b1;
          end
        end
      end
      ST_NEXT: begin
        walk_clr = 1'b1;
        if (pass_last) begin
          st_nx = ST_IDLE;
        end else begin
          st_nx    = ST_WRITE;
          pass_adv = 1'b1;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      mask_q   <= '0;
      err_bits <= '0;
      done     <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= (st == ST_NEXT) && pass_last;
      if (evt_cmp) mask_q <= mism;
      if ((st == ST_IDLE) && start) err_bits <= '0;
      else if (evt_cmp)             err_bits <= err_bits + ERR_W'(ones(mism));
    end
  end

  assign refresh_en = !((st == ST_WAIT) || (st == ST_RD_REQ) ||
                        (st == ST_RD_CMP) || (st == ST_REPORT));
  assign cmd_valid  = (st == ST_WRITE) || (st == ST_RD_REQ);
  assign cmd_write  = (st == ST_WRITE);
  assign cmd_row    = row;
  assign cmd_col    = col;
  assign cmd_wdata  = expect_w;
  assign pat_row    = row;
  assign pat_col    = col;
  assign pat_round  = rnd;
  assign fail_valid = (st == ST_REPORT);
  assign fail_row   = row;
  assign fail_col   = col;
  assign fail_mask  = mask_q;
  assign fail_step  = step;
  assign fail_inv   = inv;
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
  parameter int ROW_W  = 10,
  parameter int COL_W  = 7,
  parameter int DATA_W = 64,
  parameter int ERR_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              refresh_en,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_write,
  input logic [ROW_W-1:0]  cmd_row,
  input logic [COL_W-1:0]  cmd_col,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              fail_valid,
  input logic              fail_ready,
  input logic [ROW_W-1:0]  fail_row,
  input logic [COL_W-1:0]  fail_col,
  input logic [DATA_W-1:0] fail_mask,
  input logic              done,
  input logic [ERR_W-1:0]  err_bits,
  input logic              evt_last_write,
  input logic              evt_wait_expired
);
  assert_write_refresh_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |-> refresh_en);

  assert_hold_then_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wait_expired |=> (cmd_valid && !cmd_write));

  assert_refresh_off_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last_write |=> !refresh_en);

  assert_read_refresh_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_valid && !cmd_write) || fail_valid) |-> !refresh_en);

  assert_fail_mask_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |-> (fail_mask != '0));

  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_valid && !fail_ready) |=> (fail_valid && $stable(fail_mask) &&
                                     $stable(fail_row) && $stable(fail_col)));

  assert_fail_blocks_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_valid |-> !cmd_valid);

  assert_err_monotonic_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (err_bits >= $past(err_bits)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !cmd_valid && refresh_en));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_write) &&
      $stable(cmd_row) && $stable(cmd_col) && $stable(cmd_wdata)));
endmodule

bind retention_sequencer rts_checker #(
  .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .refresh_en(refresh_en),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
  .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
  .fail_valid(fail_valid), .fail_ready(fail_ready), .fail_row(fail_row),
  .fail_col(fail_col), .fail_mask(fail_mask), .done(done), .err_bits(err_bits),
  .evt_last_write(evt_last_write), .evt_wait_expired(evt_wait_expired)
);

// File: tb/retention_sequencer_tb.sv
module retention_sequencer_tb;
  localparam int ROWS = 4, COLS = 2, DW = 8, STEPS = 3, ROUNDS = 2;
  localparam int WW = 16, EW = 16;
  localparam int CELLS = ROWS * COLS;
  localparam int NPASS = ROUNDS * STEPS * 2;
  localparam int BASE = 10, STEPC = 150;
  localparam int LIMIT = 150000;
  // Leak table: {row, col, leak mask, first failing step, cycles before leak}
  localparam int NLEAK = 3;
  localparam logic [47:0] LEAK [NLEAK] = '{
    {8'd0, 8'd1, 8'h06, 8'd0, 16'd0},
    {8'd1, 8'd0, 8'h11, 8'd1, 16'd100},
    {8'd3, 8'd1, 8'h80, 8'd2, 16'd250}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [WW-1:0] base_wait = WW'(BASE), step_wait = WW'(STEPC);
  logic refresh_en, cmd_valid, cmd_ready = 1'b0, cmd_write;
  logic [1:0] cmd_row, pat_row, fail_row;
  logic cmd_col, pat_col, pat_round, fail_col, fail_valid, fail_ready = 1'b0, fail_inv;
  logic [DW-1:0] cmd_wdata, rd_data = '0, pat_data, fail_mask;
  logic rd_valid = 1'b0, done;
  logic [1:0] fail_step;
  logic [EW-1:0] err_bits;

  always #10 clk = ~clk;

  function automatic logic [7:0] gen(input logic [1:0] r, input logic c, input logic rd);
    return 8'hA6 ^ (8'(r) * 8'd29 + 8'(c) * 8'd71 + 8'(rd) * 8'd13);
  endfunction
  assign pat_data = gen(pat_row, pat_col, pat_round);

  retention_sequencer #(.ROWS(ROWS), .COLS(COLS), .DATA_W(DW), .STEPS(STEPS),
    .ROUNDS(ROUNDS), .WAIT_W(WW), .ERR_W(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_wait(base_wait),
    .step_wait(step_wait), .refresh_en(refresh_en), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_write(cmd_write), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pat_row(pat_row), .pat_col(pat_col),
    .pat_round(pat_round), .pat_data(pat_data), .fail_valid(fail_valid),
    .fail_ready(fail_ready), .fail_row(fail_row), .fail_col(fail_col),
    .fail_mask(fail_mask), .fail_step(fail_step), .fail_inv(fail_inv),
    .done(done), .err_bits(err_bits));

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [7:0] mem [CELLS];
  int lowcnt = 0, rdy_cnt = 0, frc = 0;
  logic pend = 1'b0;
  logic [7:0] pdata = '0;

  // Expected failure records, built from the leak table.
  logic [1:0] e_row [64];
  logic e_col [64];
  logic [7:0] e_mask [64];
  logic [1:0] e_step [64];
  logic e_inv [64];
  int n_exp = 0, exp_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] leak_of(input int r, input int c, input int cnt);
    logic [7:0] m = '0;
    for (int k = 0; k < NLEAK; k++)
      if (int'(LEAK[k][47:40]) == r && int'(LEAK[k][39:32]) == c &&
          cnt > int'(LEAK[k][15:0]))
        m |= LEAK[k][31:24];
    return m;
  endfunction

  // Memory, ready generators and low-refresh timer.
  initial begin
    forever begin
      @(posedge clk);
      cyc     <= cyc + 1;
      lowcnt  <= refresh_en ? 0 : lowcnt + 1;
      rdy_cnt <= rdy_cnt + 1;
      cmd_ready <= (rdy_cnt % 3) != 2;
      frc <= fail_valid ? frc + 1 : 0;
      fail_ready <= fail_valid && (frc == 1);
      pend <= cmd_valid && cmd_ready && !cmd_write;
      rd_valid <= pend;
      rd_data  <= pdata;
      if (cmd_valid && cmd_ready && cmd_write)
        mem[int'(cmd_row) * COLS + int'(cmd_col)] <= cmd_wdata;
      if (cmd_valid && cmd_ready && !cmd_write)
        pdata <= mem[int'(cmd_row) * COLS + int'(cmd_col)] &
                 ~leak_of(int'(cmd_row), int'(cmd_col), lowcnt);
    end
  end

  // Monitor, sampling between edges.
  bit mon_en = 1'b1, gap_pend = 1'b0, st_prev = 1'b0;
  int wr_cnt = 0, rd_cnt = 0, fail_idx = 0, done_cnt = 0, last_wr_cyc = 0;
  logic p_write; logic [1:0] p_row; logic p_col; logic [7:0] p_wdata;
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rst_n) begin
        if (st_prev) begin
          chk(cmd_valid && cmd_write == p_write && cmd_row == p_row &&
              cmd_col == p_col && cmd_wdata == p_wdata,
              "R10", "stalled command changed", int'(cmd_wdata), int'(p_wdata));
        end
        st_prev = cmd_valid && !cmd_ready;
        p_write = cmd_write; p_row = cmd_row; p_col = cmd_col; p_wdata = cmd_wdata;
        if (cmd_valid && cmd_ready && cmd_write) begin
          automatic int p = wr_cnt / CELLS, idx = wr_cnt % CELLS;
          automatic int r = p / (2 * STEPS);
          automatic logic iv = p[0];
          automatic int er = idx / COLS, ec = idx % COLS;
          automatic logic [7:0] ew = gen(2'(er), 1'(ec), 1'(r)) ^ {8{iv}};
          chk(int'(cmd_row) == er && int'(cmd_col) == ec, "R2", "write address",
              int'(cmd_row) * COLS + int'(cmd_col), idx);
          chk(cmd_wdata == ew, "R2", "write data", int'(cmd_wdata), int'(ew));
          chk(refresh_en == 1'b1, "R2", "refresh during write", int'(refresh_en), 1);
          last_wr_cyc = cyc;
          if (idx == CELLS - 1) gap_pend = 1'b1;
          wr_cnt++;
        end
        if (cmd_valid && !cmd_write && gap_pend) begin
          automatic int s = ((wr_cnt - 1) / CELLS / 2) % STEPS;
          chk(cyc - last_wr_cyc == BASE + STEPC * s + 2, "R3", "hold gap",
              cyc - last_wr_cyc, BASE + STEPC * s + 2);
          gap_pend = 1'b0;
        end
        if (cmd_valid && cmd_ready && !cmd_write) begin
          automatic int idx = rd_cnt % CELLS;
          chk(refresh_en == 1'b0, "R4", "refresh during read", int'(refresh_en), 0);
          chk(int'(cmd_row) * COLS + int'(cmd_col) == idx, "R5", "read address",
              int'(cmd_row) * COLS + int'(cmd_col), idx);
          rd_cnt++;
        end
        if (fail_valid && !fail_ready)
          chk(!cmd_valid, "R7", "command during stalled report", int'(cmd_valid), 0);
        if (fail_valid && fail_ready) begin
          chk(refresh_en == 1'b0, "R4", "refresh during report", int'(refresh_en), 0);
          if (fail_idx < n_exp) begin
            chk(fail_row == e_row[fail_idx] && fail_col == e_col[fail_idx],
                "R6", "fail location", int'(fail_row) * COLS + int'(fail_col),
                int'(e_row[fail_idx]) * COLS + int'(e_col[fail_idx]));
            chk(fail_mask == e_mask[fail_idx], "R6", "fail mask",
                int'(fail_mask), int'(e_mask[fail_idx]));
            chk(fail_step == e_step[fail_idx] && fail_inv == e_inv[fail_idx],
                "R5", "fail step/complement", int'({fail_step, fail_inv}),
                int'({e_step[fail_idx], e_inv[fail_idx]}));
          end else begin
            chk(1'b0, "R6", "unexpected failure record", fail_idx, n_exp);
          end
          fail_idx++;
        end
        if (done) done_cnt++;
      end
    end
  end

  initial begin
    // Build expected records by walking passes, locations and the leak table.
    for (int p = 0; p < NPASS; p++) begin
      automatic int r = p / (2 * STEPS), s = (p / 2) % STEPS;
      automatic logic iv = p[0];
      for (int idx = 0; idx < CELLS; idx++) begin
        automatic logic [7:0] st = gen(2'(idx / COLS), 1'(idx % COLS), 1'(r)) ^ {8{iv}};
        automatic logic [7:0] lk = '0;
        for (int k = 0; k < NLEAK; k++)
          if (int'(LEAK[k][47:40]) * COLS + int'(LEAK[k][39:32]) == idx &&
              s >= int'(LEAK[k][23:16]))
            lk |= LEAK[k][31:24];
        if ((st & lk) != 0) begin
          e_row[n_exp] = 2'(idx / COLS); e_col[n_exp] = 1'(idx % COLS);
          e_mask[n_exp] = st & lk; e_step[n_exp] = 2'(s); e_inv[n_exp] = iv;
          exp_err += $countones(st & lk);
          n_exp++;
        end
      end
    end

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(refresh_en && !cmd_valid && !fail_valid && !done && err_bits == 0,
        "R1", "reset outputs", int'({refresh_en, cmd_valid, fail_valid, done}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(refresh_en && !cmd_valid && err_bits == 0, "R1", "after reset",
        int'({refresh_en, cmd_valid}), 2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == 0 && cyc < LIMIT) @(negedge clk);
    chk(cyc < LIMIT, "R9", "watchdog expired", cyc, LIMIT);

    // R9: single pulse, then idle
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!cmd_valid && refresh_en && !done, "R9", "idle after done",
          int'({cmd_valid, refresh_en, done}), 2);
    end
    chk(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
    chk(wr_cnt == NPASS * CELLS, "R5", "write count", wr_cnt, NPASS * CELLS);
    chk(rd_cnt == NPASS * CELLS, "R5", "read count", rd_cnt, NPASS * CELLS);
    chk(fail_idx == n_exp, "R6", "failure record count", fail_idx, n_exp);
    chk(int'(err_bits) == exp_err, "R8", "mismatched bit total", int'(err_bits), exp_err);

    // R8: a new start clears the bit total
    mon_en = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_bits == 0, "R8", "clear on start", int'(err_bits), 0);
    rst_n = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule